// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns three active-low external interrupt pins into interrupt requests for a processor core. Each pin first passes through a two-stage synchroniser. A per-line mode bit then picks how the pin is read. In level mode, the line requests for as long as the pin is held low. In edge mode, a high-to-low transition sets a pending flag, and that flag stays set until the core acknowledges the line.

A per-line enable bit gates new requests. Clearing the enable bit does not withdraw an edge request that was already captured. That request keeps asserting its output and can still be serviced. Further edges on a disabled line are dropped.

Software reaches the mode and enable bits through two 8-bit registers on a simple synchronous bus. Writes take effect on the clock edge. Reads are combinational from the address. The block presents the raw per-line request vector, a valid flag and the index of the most urgent active line. The core returns a one-cycle acknowledge strobe that carries a line index.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every mode bit and every enable bit is 0. Both registers read 0xF8, and no request, valid flag or index is asserted.
- R2: The mode register is at address 0xFFC6 and the enable register is at 0xFFC7. Bit i of each register (i = 0..2) belongs to line i. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: Bits 7 to 3 of both registers always read as 1, whatever is written to them.
- R4: A line in level mode (mode bit 0) with its enable bit set asserts req_o[i] while its synchronised pin is low. A pin change is visible on req_o after the second rising clock edge.
- R5: A line in edge mode (mode bit 1) with its enable bit set latches a falling edge on its pin. req_o[i] rises after the third rising clock edge following the pin change, and it stays high after the pin returns high.
- R6: A falling edge on a line whose enable bit is 0 is never latched, in either mode.
- R7: Clearing the enable bit of a line with a latched edge request keeps that request asserted on req_o.
- R8: An acknowledge strobe with index i clears line i's latched request. If a falling edge is detected on line i in the same cycle as the acknowledge, the request stays set. Index 3 clears nothing.
- R9: Writing the mode register leaves every latched request unchanged.
- R10: req_valid_o is high when any bit of req_o is high. req_idx_o is then the lowest-numbered active line, so line 0 has the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_n_i | input | 3 | Active-low external request pins |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| ack_idx_i | input | 2 | Line index being acknowledged |
| req_o | output | 3 | Per-line active request |
| req_valid_o | output | 1 | Any request active |
| req_idx_o | output | 2 | Lowest-numbered active line |

## Verification
The hardest situation to reach from the ports is the race between an acknowledge and a new falling edge on the same line. The acknowledge has to land in exactly the cycle in which the synchronised pin shows its high-to-low step. The bench drives the pin low on a falling clock edge, counts two rising edges through the synchroniser, and then asserts the acknowledge for the following edge. It checks that the request survives, and repeats the sequence without the edge to show that a plain acknowledge clears the request. A sweep over all 64 mode/enable settings and all eight pin patterns predicts every latched request from the sequence of pin transitions.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int NUM_LINES   = 3;
    localparam int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int SYNC_STAGES = 2;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 16;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 16'hFFC6;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 16'hFFC7;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_EDGE  = 1'b1
    } sense_mode_e;

    typedef struct packed {
        logic [NUM_LINES-1:0] mode;
        logic [NUM_LINES-1:0] enable;
    } xirq_cfg_t;

    // Register image: line bits at the bottom, reserved bits read as ones.
    function automatic logic [DATA_W-1:0] reg_image(input logic [NUM_LINES-1:0] bits);
        logic [DATA_W-1:0] img;
        img = '1;
        img[NUM_LINES-1:0] = bits;
        return img;
    endfunction

endpackage

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output xirq_cfg_t         cfg
);

    xirq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sel && wr) begin
            if (addr == ADDR_MODE) begin
                cfg_q.mode <= wdata[NUM_LINES-1:0];
            end
            if (addr == ADDR_ENABLE) begin
                cfg_q.enable <= wdata[NUM_LINES-1:0];
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_MODE:   rdata = reg_image(cfg_q.mode);
            ADDR_ENABLE: rdata = reg_image(cfg_q.enable);
            default:     rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_n,
    input  logic        enable,
    input  sense_mode_e mode,
    input  logic        ack_hit,
    output logic        req,
    output logic        pend
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   sampled;
    logic                   fall;

    // Pin synchroniser; idle level of an active-low pin is high.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= sampled;
        end
    end

    assign sampled = sync_q[SYNC_STAGES-1];
    assign fall    = prev_q && !sampled;

    // A captured edge takes precedence over a simultaneous acknowledge.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (fall && enable && (mode == MODE_EDGE)) begin
            pend_q <= 1'b1;
        end else if (ack_hit) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_EDGE:  req = pend_q;
            default:    req = !sampled && enable;
        endcase
    end

    assign pend = pend_q;

endmodule

// File: rtl/xirq_prio.sv
module xirq_prio
    import xirq_pkg::*;
(
    input  logic [NUM_LINES-1:0] req,
    output logic                 valid,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        idx   = '0;
        valid = |req;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [2:0]        irq_n_i,
    input  logic              ack_i,
    input  logic [1:0]        ack_idx_i,
    output logic [2:0]        req_o,
    output logic              req_valid_o,
    output logic [1:0]        req_idx_o
);

    xirq_cfg_t            cfg;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] ack_hit;
    logic [NUM_LINES-1:0] line_req;

    xirq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    assign mode_q = cfg.mode;
    assign en_q   = cfg.enable;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign ack_hit[g] = ack_i && (ack_idx_i == IDX_W'(g));

        xirq_line u_line (
            .clk     (clk),
            .rst     (rst),
            .pin_n   (irq_n_i[g]),
            .enable  (en_q[g]),
            .mode    (sense_mode_e'(mode_q[g])),
            .ack_hit (ack_hit[g]),
            .req     (line_req[g]),
            .pend    (pend_q[g])
        );
    end

    xirq_prio u_prio (
        .req   (line_req),
        .valid (req_valid_o),
        .idx   (req_idx_o)
    );

    assign req_o = line_req;

endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_rdata,
    input logic [2:0]  req_o,
    input logic        req_valid_o,
    input logic [1:0]  req_idx_o,
    input logic        ack_i,
    input logic [1:0]  ack_idx_i,
    input logic [2:0]  mode_q,
    input logic [2:0]  en_q,
    input logic [2:0]  pend_q
);

    logic [2:0] ack_mask;
    logic [2:0] below_mask;
    logic       idx_active;

    always_comb begin
        ack_mask = 3'b000;
        if (ack_i) begin
            case (ack_idx_i)
                2'd0:    ack_mask = 3'b001;
                2'd1:    ack_mask = 3'b010;
                2'd2:    ack_mask = 3'b100;
                default: ack_mask = 3'b000;
            endcase
        end
        case (req_idx_o)
            2'd0:    begin below_mask = 3'b000; idx_active = req_o[0]; end
            2'd1:    begin below_mask = 3'b001; idx_active = req_o[1]; end
            2'd2:    begin below_mask = 3'b011; idx_active = req_o[2]; end
            default: begin below_mask = 3'b111; idx_active = 1'b0;     end
        endcase
    end

    // R1: configuration and pending flags are clear right after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (mode_q == 3'b000 && en_q == 3'b000 && pend_q == 3'b000));

    // R3: reserved bits read as ones at either register address
    p_reserved_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 16'hFFC6 || bus_addr == 16'hFFC7) |-> (bus_rdata[7:3] == 5'b11111));

    // R4: a level-mode request requires the enable bit
    p_level_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        ((req_o & ~mode_q & ~en_q) == 3'b000));

    // R6: a new pending flag only appears on an enabled edge-mode line
    p_new_pend_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q & mode_q)) == 3'b000));

    // R7: pending flags persist unless acknowledged, even with enable cleared
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q & ~ack_mask) & ~pend_q) == 3'b000));

    // R10: valid flag tracks the request vector
    p_valid_any_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid_o == (req_o != 3'b000));

    // R10: reported line is active and no lower-numbered line is
    p_lowest_wins_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (idx_active && ((req_o & below_mask) == 3'b000)));

endmodule

bind xirq_ctrl xirq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .req_o       (req_o),
    .req_valid_o (req_valid_o),
    .req_idx_o   (req_idx_o),
    .ack_i       (ack_i),
    .ack_idx_i   (ack_idx_i),
    .mode_q      (mode_q),
    .en_q        (en_q),
    .pend_q      (pend_q)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [2:0]  irq_n_i = 3'b111;
    logic        ack_i = 1'b0;
    logic [1:0]  ack_idx_i = 2'd0;
    logic [2:0]  req_o;
    logic        req_valid_o;
    logic [1:0]  req_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [15:0] A_MODE = 16'hFFC6;
    localparam logic [15:0] A_EN   = 16'hFFC7;

    always #5 clk = ~clk;

    xirq_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_n_i     (irq_n_i),
        .ack_i       (ack_i),
        .ack_idx_i   (ack_idx_i),
        .req_o       (req_o),
        .req_valid_o (req_valid_o),
        .req_idx_o   (req_idx_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [15:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic ack_line(input logic [1:0] idx);
        ack_i = 1'b1; ack_idx_i = idx;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic check_req(input logic [2:0] exp, input string tag);
        logic [1:0] eidx;
        eidx = exp[0] ? 2'd0 : (exp[1] ? 2'd1 : 2'd2);
        check(req_o == exp, tag, req_o, exp);
        check(req_valid_o == (exp != 3'b000), {tag, " R10 valid"}, req_valid_o, exp != 3'b000);
        if (exp != 3'b000)
            check(req_idx_o == eidx, {tag, " R10 index"}, req_idx_o, eidx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // R1: reset state
        reg_check(A_MODE, 8'hF8, "R1 mode reg");
        reg_check(A_EN,   8'hF8, "R1 enable reg");
        check_req(3'b000, "R1 no request");

        // R2: stray address write/read
        reg_write(16'hFFC5, 8'hFF);
        reg_check(A_MODE, 8'hF8, "R2 stray write mode");
        reg_check(A_EN,   8'hF8, "R2 stray write enable");
        reg_check(16'hFFC5, 8'h00, "R2 unmapped read");
        reg_write(A_EN, 8'h05);
        reg_check(A_EN,   8'hFD, "R2 enable bits");
        reg_check(A_MODE, 8'hF8, "R2 mode untouched");

        // R3: reserved bits
        reg_write(A_EN, 8'h00);
        reg_check(A_EN, 8'hF8, "R3 zero write");
        reg_write(A_MODE, 8'hFF);
        reg_check(A_MODE, 8'hFF, "R3 ones write");
        reg_write(A_MODE, 8'h00);

        // R4: level latency, line 0
        reg_write(A_EN, 8'h01);
        irq_n_i = 3'b110;
        cycles(1);
        check_req(3'b000, "R4 after one edge");
        cycles(1);
        check_req(3'b001, "R4 after two edges");
        irq_n_i = 3'b111;
        cycles(2);
        check_req(3'b000, "R4 release");

        // R5: edge latency, line 1
        reg_write(A_MODE, 8'h02);
        reg_write(A_EN, 8'h02);
        irq_n_i = 3'b101;
        cycles(2);
        check_req(3'b000, "R5 after two edges");
        cycles(1);
        check_req(3'b010, "R5 after three edges");
        irq_n_i = 3'b111;
        cycles(4);
        check_req(3'b010, "R5 held after release");

        // R9: mode rewrite keeps the latch
        reg_write(A_MODE, 8'h00);
        cycles(1);
        check_req(3'b000, "R9 level view, pin high");
        reg_write(A_MODE, 8'h02);
        cycles(1);
        check_req(3'b010, "R9 latch kept");

        // R8: index 3 clears nothing, index 1 clears
        ack_line(2'd3);
        check_req(3'b010, "R8 index 3 no effect");
        ack_line(2'd1);
        check_req(3'b000, "R8 ack clears");

        // R8: edge in the same cycle as acknowledge wins
        irq_n_i = 3'b101;
        cycles(3);
        check_req(3'b010, "R8 set before race");
        irq_n_i = 3'b111;
        cycles(4);
        irq_n_i = 3'b101;
        cycles(2);
        ack_line(2'd1);
        check_req(3'b010, "R8 edge beats ack");
        ack_line(2'd1);
        check_req(3'b000, "R8 plain ack after race");
        irq_n_i = 3'b111;
        cycles(4);

        // R7: disable keeps a latched request; R6: new edges dropped
        reg_write(A_MODE, 8'h04);
        reg_write(A_EN, 8'h04);
        irq_n_i = 3'b011;
        cycles(4);
        reg_write(A_EN, 8'h00);
        cycles(1);
        check_req(3'b100, "R7 latched after disable");
        ack_line(2'd2);
        irq_n_i = 3'b111;
        cycles(4);
        irq_n_i = 3'b011;
        cycles(4);
        check_req(3'b000, "R6 disabled edge dropped");
        reg_write(A_EN, 8'h04);
        cycles(1);
        check_req(3'b000, "R6 nothing after re-enable");
        irq_n_i = 3'b111;
        cycles(4);

        // R4, R5, R6, R10: sweep of all settings and pin patterns
        for (int cfg = 0; cfg < 64; cfg++) begin
            logic [2:0] md, en, pend, prev, exp;
            md = cfg[2:0];
            en = cfg[5:3];
            irq_n_i = 3'b111;
            cycles(4);
            for (int l = 0; l < 3; l++) ack_line(l[1:0]);
            reg_write(A_MODE, {5'b0, md});
            reg_write(A_EN,   {5'b0, en});
            pend = 3'b000;
            prev = 3'b111;
            for (int p = 0; p < 8; p++) begin
                irq_n_i = p[2:0];
                pend = pend | (prev & ~p[2:0] & en & md);
                prev = p[2:0];
                cycles(4);
                exp = (md & pend) | (~md & ~p[2:0] & en);
                check_req(exp, "R4,R5,R6 sweep");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule